// File: doc/BRIEF.md
# Lockstep Fault-Window Output Monitor

This block sits beside two copies of one design that are driven by the same stimulus and clocked together. One copy is the golden reference. The other is the unit under test, which receives at most one injected fault per observation window. Each cycle inside a window, the block compares the two output buses. It raises a mismatch flag for every differing cycle and remembers whether the window saw any error. When the window closes, it reports the fault location that was captured when the window opened and says whether that location turned out to be sensitive.

For every fault location the block keeps two saturating counters: how many windows injected a fault there, and how many of those windows produced at least one output error. Dividing the second count by the first gives the failure probability for that location. A programmable settle interval masks comparison for the first few cycles of each window, so that a pipeline disturbed by the injection can settle first. Any external read port selects a location and returns both of its counts.

Top module: `lockstep_mon`

## Requirements
- R1: After reset, `mismatch` and `rpt_valid` are low, and both counts read zero for every location.
- R2: A compared cycle in which `gold_data` and `dut_data` differ in any bit, including any single bit of the 72-bit default width, sets `mismatch` high in the following cycle. A compared cycle with equal buses leaves it low.
- R3: A cycle with `valid` low is never compared and cannot raise `mismatch` or mark the window sensitive.
- R4: A window opens in the cycle where `win_start` is accepted. That cycle itself is not compared. With `settle_cyc` = S captured at the start, the next S cycles are masked, and comparison begins in cycle S+1 after the start.
- R5: Outside an open window, no comparison takes place, whatever the buses hold.
- R6: In the cycle after an accepted `win_end`, `rpt_valid` pulses for exactly one cycle. `rpt_loc` equals the `loc_idx` captured at window start. `rpt_sensitive` is 1 if any compared cycle of the window mismatched, and the `win_end` cycle itself counts.
- R7: Within one window, the mismatch state is sticky: several mismatching cycles count as a single error, and the state is cleared when the window closes.
- R8: Each closed window adds one to the injection count of its location, and adds one to the error count if it was sensitive. `rd_inj` and `rd_err` show the updated counts for `rd_idx` from the `rpt_valid` cycle on.
- R9: Both counts saturate at 2^CW-1 and never wrap.
- R10: A `win_start` while a window is open is ignored, and the captured location is kept. A `win_end` while no window is open produces no report and changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gold_data | input | DW | Reference copy output bus |
| dut_data | input | DW | Unit-under-test output bus |
| valid | input | 1 | Both buses carry a comparable beat |
| win_start | input | 1 | Open an observation window |
| win_end | input | 1 | Close the observation window |
| loc_idx | input | LW | Fault location injected for the window being opened |
| settle_cyc | input | SW | Masked cycles after window start |
| rd_idx | input | LW | Location selected for count readout |
| mismatch | output | 1 | A compared cycle differed (one cycle later) |
| rpt_valid | output | 1 | One-cycle end-of-window report strobe |
| rpt_loc | output | LW | Location of the reported window |
| rpt_sensitive | output | 1 | Reported window saw an output error |
| rd_inj | output | CW | Injection count of `rd_idx` |
| rd_err | output | CW | Error-window count of `rd_idx` |

## Verification
A settle counter that is off by one shows up in the very next window as a `mismatch` pulse one cycle too early or too late, and it flips `rpt_sensitive` when the only difference falls on the masked edge. A sticky flag that is not cleared makes the next clean window report sensitive at its close. A captured location that gets corrupted appears in `rpt_loc`, and the counts then shift to the wrong entry, which the readout exposes in the report cycle. A counter that wraps instead of saturating reads near zero once a location has seen more windows than the count can hold.

// File: rtl/lm_pkg.sv
package lm_pkg;
   // number of compare lanes covering a bus
   function automatic int lane_count(input int dw, input int lane_w);
      return (dw + lane_w - 1) / lane_w;
   endfunction
endpackage

// File: rtl/lm_compare.sv
module lm_compare #(
   parameter int DW     = 72,
   parameter int SW     = 8,
   parameter int LANE_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] gold_data,
   input  logic [DW-1:0] dut_data,
   input  logic          valid,
   input  logic          open_q,
   input  logic          start_acc,
   input  logic [SW-1:0] settle_cyc,
   output logic          hit
);
   localparam int NLANE = lm_pkg::lane_count(DW, LANE_W);
   localparam int PW    = NLANE * LANE_W;

   logic [PW-1:0]    diff_pad;
   logic [NLANE-1:0] lane_diff;
   logic [SW-1:0]    settle_q;

   assign diff_pad = PW'(gold_data ^ dut_data);

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign lane_diff[l] = |diff_pad[l*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         settle_q <= '0;
      end else if (start_acc) begin
         settle_q <= settle_cyc;
      end else if (open_q && settle_q != '0) begin
         settle_q <= settle_q - 1'b1;
      end
   end

   assign hit = open_q && valid && (settle_q == '0) && (|lane_diff);
endmodule

// File: rtl/lm_window.sv
module lm_window #(
   parameter int LW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          win_start,
   input  logic          win_end,
   input  logic [LW-1:0] loc_idx,
   input  logic          hit,
   output logic          open_q,
   output logic          start_acc,
   output logic          end_acc,
   output logic [LW-1:0] cur_loc,
   output logic          win_sens,
   output logic          mismatch,
   output logic          rpt_valid,
   output logic [LW-1:0] rpt_loc,
   output logic          rpt_sensitive
);
   logic sticky_q;

   assign start_acc = win_start && !open_q;
   assign end_acc   = win_end && open_q;
   assign win_sens  = sticky_q || hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q        <= 1'b0;
         sticky_q      <= 1'b0;
         cur_loc       <= '0;
         mismatch      <= 1'b0;
         rpt_valid     <= 1'b0;
         rpt_loc       <= '0;
         rpt_sensitive <= 1'b0;
      end else begin
         mismatch  <= hit;
         rpt_valid <= end_acc;
         if (start_acc) begin
            open_q   <= 1'b1;
            sticky_q <= 1'b0;
            cur_loc  <= loc_idx;
         end else if (end_acc) begin
            open_q        <= 1'b0;
            sticky_q      <= 1'b0;
            rpt_loc       <= cur_loc;
            rpt_sensitive <= win_sens;
         end else if (hit) begin
            sticky_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/lm_counts.sv
module lm_counts #(
   parameter int LW = 4,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic [LW-1:0] upd_loc,
   input  logic          upd_err,
   input  logic [LW-1:0] rd_idx,
   output logic [CW-1:0] rd_inj,
   output logic [CW-1:0] rd_err
);
   localparam int NLOC = 1 << LW;
   localparam logic [CW-1:0] CMAX = '1;

   logic [CW-1:0] inj_q [NLOC];
   logic [CW-1:0] err_q [NLOC];

   for (genvar e = 0; e < NLOC; e++) begin : g_ent
      logic sel;
      assign sel = upd && (upd_loc == LW'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            inj_q[e] <= '0;
            err_q[e] <= '0;
         end else if (sel) begin
            if (inj_q[e] != CMAX) inj_q[e] <= inj_q[e] + 1'b1;
            if (upd_err && err_q[e] != CMAX) err_q[e] <= err_q[e] + 1'b1;
         end
      end
   end

   assign rd_inj = inj_q[rd_idx];
   assign rd_err = err_q[rd_idx];
endmodule

// File: rtl/lockstep_mon.sv
module lockstep_mon #(
   parameter int DW     = 72,
   parameter int LW     = 4,
   parameter int CW     = 16,
   parameter int SW     = 8,
   parameter int LANE_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] gold_data,
   input  logic [DW-1:0] dut_data,
   input  logic          valid,
   input  logic          win_start,
   input  logic          win_end,
   input  logic [LW-1:0] loc_idx,
   input  logic [SW-1:0] settle_cyc,
   input  logic [LW-1:0] rd_idx,
   output logic          mismatch,
   output logic          rpt_valid,
   output logic [LW-1:0] rpt_loc,
   output logic          rpt_sensitive,
   output logic [CW-1:0] rd_inj,
   output logic [CW-1:0] rd_err
);
   if (DW < 1)                  begin : g_bad_dw   $error("DW must be at least 1"); end
   if (LW < 1 || LW > 10)       begin : g_bad_lw   $error("LW must be 1..10"); end
   if (CW < 1)                  begin : g_bad_cw   $error("CW must be at least 1"); end
   if (SW < 1)                  begin : g_bad_sw   $error("SW must be at least 1"); end
   if (LANE_W < 1 || LANE_W > DW) begin : g_bad_ln $error("LANE_W must be 1..DW"); end

   logic          win_open;
   logic          start_acc;
   logic          end_acc;
   logic          hit;
   logic          win_sens;
   logic [LW-1:0] cur_loc;

   lm_compare #(.DW(DW), .SW(SW), .LANE_W(LANE_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .gold_data(gold_data), .dut_data(dut_data),
      .valid(valid), .open_q(win_open), .start_acc(start_acc),
      .settle_cyc(settle_cyc), .hit(hit)
   );

   lm_window #(.LW(LW)) u_win (
      .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_end(win_end),
      .loc_idx(loc_idx), .hit(hit), .open_q(win_open), .start_acc(start_acc),
      .end_acc(end_acc), .cur_loc(cur_loc), .win_sens(win_sens),
      .mismatch(mismatch), .rpt_valid(rpt_valid), .rpt_loc(rpt_loc),
      .rpt_sensitive(rpt_sensitive)
   );

   lm_counts #(.LW(LW), .CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .upd(end_acc), .upd_loc(cur_loc),
      .upd_err(win_sens), .rd_idx(rd_idx), .rd_inj(rd_inj), .rd_err(rd_err)
   );
endmodule

// File: rtl/lockstep_mon_chk.sv
module lockstep_mon_chk #(
   parameter int DW = 72,
   parameter int LW = 4,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] gold_data,
   input logic [DW-1:0] dut_data,
   input logic          valid,
   input logic          win_end,
   input logic          win_open,
   input logic [LW-1:0] rd_idx,
   input logic          mismatch,
   input logic          rpt_valid,
   input logic [CW-1:0] rd_inj,
   input logic [CW-1:0] rd_err
);
   AST_MISMATCH_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |-> $past(gold_data != dut_data)); // R2
   AST_MISMATCH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |-> $past(valid)); // R3
   AST_MISMATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |-> $past(win_open)); // R5
   AST_RPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |=> !rpt_valid); // R6
   AST_RPT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |-> $past(win_end && win_open)); // R6
   AST_ERR_LE_INJ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err <= rd_inj); // R8
   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_inj) == {CW{1'b1}} && $stable(rd_idx)) |-> rd_inj == {CW{1'b1}}); // R9
endmodule

bind lockstep_mon lockstep_mon_chk #(.DW(DW), .LW(LW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .gold_data(gold_data), .dut_data(dut_data),
   .valid(valid), .win_end(win_end), .win_open(win_open), .rd_idx(rd_idx),
   .mismatch(mismatch), .rpt_valid(rpt_valid), .rd_inj(rd_inj), .rd_err(rd_err)
);

// File: tb/lockstep_mon_bench.sv
`timescale 1ns/1ps
module lockstep_mon_bench;
   localparam int DW = 72;
   localparam int LW = 3;
   localparam int CW = 3;
   localparam int SW = 2;
   localparam int NLOC = 1 << LW;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [DW-1:0] gold_data, dut_data;
   logic          valid, win_start, win_end;
   logic [LW-1:0] loc_idx, rd_idx;
   logic [SW-1:0] settle_cyc;
   logic          mismatch, rpt_valid, rpt_sensitive;
   logic [LW-1:0] rpt_loc;
   logic [CW-1:0] rd_inj, rd_err;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int exp_inj [NLOC];
   int exp_err [NLOC];

   always #2 clk = ~clk;

   lockstep_mon #(.DW(DW), .LW(LW), .CW(CW), .SW(SW), .LANE_W(8)) u_lockstep_mon (
      .clk(clk), .rst_n(rst_n), .gold_data(gold_data), .dut_data(dut_data),
      .valid(valid), .win_start(win_start), .win_end(win_end), .loc_idx(loc_idx),
      .settle_cyc(settle_cyc), .rd_idx(rd_idx), .mismatch(mismatch),
      .rpt_valid(rpt_valid), .rpt_loc(rpt_loc), .rpt_sensitive(rpt_sensitive),
      .rd_inj(rd_inj), .rd_err(rd_err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle();
      valid = 1'b0; win_start = 1'b0; win_end = 1'b0;
      gold_data = '0; dut_data = '0;
   endtask

   task automatic read_check(input int loc, input string req);
      rd_idx = LW'(loc);
      #1;
      chk(rd_inj == CW'(exp_inj[loc]), {req, " inj count"}, rd_inj, exp_inj[loc]);
      chk(rd_err == CW'(exp_err[loc]), {req, " err count"}, rd_err, exp_err[loc]);
   endtask

   // cycle 0 = start, cycles 1..len carry data, win_end on cycle len
   task automatic run_win(input int loc, input int s, input int len, input int mm,
                          input int vm, input int bitb, input int dup_at);
      bit sens = 1'b0;
      bit exp_m = 1'b0;
      @(negedge clk);
      idle();
      win_start = 1'b1; loc_idx = LW'(loc); settle_cyc = SW'(s);
      for (int i = 1; i <= len; i++) begin
         @(negedge clk);
         chk(mismatch == exp_m, "R2 R3 R4 mismatch flag", mismatch, exp_m);
         win_start = (i == dup_at);
         loc_idx   = (i == dup_at) ? LW'((loc + 3) % NLOC) : LW'(loc);
         valid     = vm[i];
         gold_data = DW'(64'h9E37_79B9_7F4A_7C15 * (i + loc * 16 + s * 256)) ^ {8'(i), 64'h0};
         dut_data  = gold_data ^ (mm[i] ? (DW'(1) << bitb) : '0);
         win_end   = (i == len);
         exp_m = vm[i] && mm[i] && (i > s);
         if (exp_m) sens = 1'b1;
      end
      @(negedge clk);
      chk(mismatch == exp_m, "R2 mismatch on end cycle", mismatch, exp_m);
      chk(rpt_valid == 1'b1, "R6 report strobe", rpt_valid, 1);
      chk(rpt_loc == LW'(loc), "R6 R10 report location", rpt_loc, loc);
      chk(rpt_sensitive == sens, "R6 R7 sensitive bit", rpt_sensitive, sens);
      if (exp_inj[loc] < CMAX) exp_inj[loc]++;
      if (sens && exp_err[loc] < CMAX) exp_err[loc]++;
      idle();
      read_check(loc, "R8 R9");
      @(negedge clk);
      chk(rpt_valid == 1'b0, "R6 report one cycle", rpt_valid, 0);
      chk(mismatch == 1'b0, "R7 flag after close", mismatch, 0);
   endtask

   initial begin
      for (int k = 0; k < NLOC; k++) begin exp_inj[k] = 0; exp_err[k] = 0; end
      rst_n = 1'b0; idle(); loc_idx = '0; settle_cyc = '0; rd_idx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mismatch == 1'b0, "R1 mismatch after reset", mismatch, 0);
      chk(rpt_valid == 1'b0, "R1 report after reset", rpt_valid, 0);
      for (int k = 0; k < NLOC; k++) read_check(k, "R1 reset");

      // settle x location sweep, mixed valid and mismatch patterns
      for (int s = 0; s < 4; s++) begin
         for (int loc = 0; loc < NLOC; loc++) begin
            int mm = (loc == s) ? 0 : (((loc * 37 + s * 11 + 5) % 64) << 1);
            int vm = 32'h7E & ~(1 << (1 + (loc + s) % 6));
            run_win(loc, s, 6, mm, vm, (loc * 9 + s * 23) % DW, 0);
         end
      end

      // mismatch only on the last masked cycle: not sensitive (R4)
      run_win(2, 3, 4, 32'h08, 32'h1E, 5, 0);
      // mismatch first right after mask (R4)
      run_win(2, 2, 4, 32'h08, 32'h1E, 6, 0);
      // all cycles mismatch: one error only (R7), then a clean window (R7)
      run_win(5, 0, 6, 32'h7E, 32'h7E, 71, 0);
      run_win(5, 0, 6, 0, 32'h7E, 0, 0);
      // second start inside window ignored (R10)
      run_win(1, 0, 5, 32'h04, 32'h3E, 30, 2);

      // win_end with no open window: no report, no count change (R10)
      @(negedge clk);
      idle(); win_end = 1'b1;
      @(negedge clk);
      idle();
      chk(rpt_valid == 1'b0, "R10 stray end no report", rpt_valid, 0);
      for (int k = 0; k < NLOC; k++) read_check(k, "R10 stray end");
      @(negedge clk);
      chk(rpt_valid == 1'b0, "R10 stray end no late report", rpt_valid, 0);

      // differing buses with no window open (R5)
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (i > 0) chk(mismatch == 1'b0, "R5 no compare outside window", mismatch, 0);
         valid = 1'b1; gold_data = DW'(i + 1); dut_data = ~gold_data;
      end
      @(negedge clk);
      chk(mismatch == 1'b0, "R5 no compare outside window", mismatch, 0);
      idle();

      // every single bit of the bus, mismatch only on win_end cycle (R2 R6)
      for (int b = 0; b < DW; b++) run_win(b % NLOC, 0, 2, 32'h04, 32'h06, b, 0);

      // saturation sweep readback (R9)
      for (int k = 0; k < NLOC; k++) read_check(k, "R9 final");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule